// File: doc/BRIEF.md
# Parity-Folded PCI Interrupt Router with Acknowledge Port

This block gathers the four level-sensitive interrupt pins (A through D) of several PCI devices and folds them onto shared interrupt lines. The line a pin lands on depends on the pin index and the device number, so pin A of adjacent slots alternates between two lines. A configuration input picks one of two output arrangements. In separate mode, each line drives its own output wire. In combined mode, all lines are ORed into a single interrupt request.

The block also holds a one-byte interrupt-acknowledge register on a simple request/response bus. A byte read of that register sends a one-cycle acknowledge strobe to an external interrupt controller. The vector the controller presents during the strobe is then returned as the read data. A write is accepted and discarded. Any access wider than one byte is refused with an error response. The interrupt controller and any priority logic sit outside the block.

The acknowledge state machine has five states: `ACK_IDLE`, `ACK_STROBE`, `ACK_READ_DONE`, `ACK_WRITE_DONE` and `ACK_REJECT`. It makes these transitions:
- idle to strobe on a byte read that hits the register;
- idle to write-done on a byte write that hits;
- idle to reject on a hit wider than one byte;
- strobe to read-done unconditionally;
- each of the three done states back to idle unconditionally.

Requests that arrive outside idle, and requests to any other address, are ignored.

Top module: `intx_router`

## Requirements
- R1: Pin p of device d (p = 0..3 for A..D, d from the device-number input of that slot) drives line index (p + d) mod 2; only the least significant bit of the device number matters.
- R2: Each line is a level: it is high while any pin mapped onto it is high and returns low once all of those pins are low.
- R3: With `sep_mode` = 1, `irq_line[1:0]` carry the two folded lines, `irq_line[3:2]` stay low, and `irq_all` stays low.
- R4: With `sep_mode` = 0, `irq_all` is the OR of every line and `irq_line` is all zero.
- R5: The interrupt outputs are registered: they reflect the pins, device numbers and mode sampled at the previous rising clock edge. After a synchronous reset (`rst_n` low), all outputs are zero.
- R6: A one-byte read (`bus_size` = 0) that hits the acknowledge address (default 0xBFFF_FFF0) raises `ctl_ack_stb` for exactly one cycle, in the cycle after the request.
- R7: The cycle after the strobe, `bus_rsp_valid` is high, `bus_rsp_err` is low, and `bus_rdata` equals the `ctl_vector` value present during the strobe cycle.
- R8: A one-byte write that hits the acknowledge address gets `bus_rsp_valid` high with `bus_rsp_err` low in the next cycle. It raises no strobe and leaves `bus_rdata` unchanged.
- R9: An access to the acknowledge address with `bus_size` of 1 (two bytes) or 2 (four bytes) gets `bus_rsp_valid` and `bus_rsp_err` high in the next cycle, with no strobe.
- R10: A request to any other address raises neither a response nor a strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sep_mode | input | 1 | 1 = separate line outputs, 0 = single combined output |
| dev_pins | input | NUM_DEV*4 | Pin levels; bits [4d+3:4d] are pins D..A of slot d |
| dev_num | input | NUM_DEV*DEVNUM_W | Device number of each slot |
| irq_line | output | 4 | Separate-mode interrupt lines |
| irq_all | output | 1 | Combined-mode interrupt request |
| bus_req | input | 1 | Single-cycle request pulse |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 32 | Byte address |
| bus_size | input | 2 | 0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes |
| bus_wdata | input | 8 | Write data (discarded) |
| bus_rdata | output | 8 | Read data from the last acknowledge read |
| bus_rsp_valid | output | 1 | Response strobe |
| bus_rsp_err | output | 1 | Response carries an error |
| ctl_ack_stb | output | 1 | Acknowledge strobe to the interrupt controller |
| ctl_vector | input | 8 | Vector from the interrupt controller |

## Verification
The bus assertions assume that a master issues a request only when no earlier transaction is still in flight. This is why a hit is expected to be answered on the very next edge. The bench keeps within this by waiting out each response, and for a miss by waiting two idle cycles, before issuing another request. The assertions also take the controller's vector as meaningful only during the strobe cycle. The bench therefore drives a decoy value outside that cycle, so that a capture in the wrong cycle shows up. Pin and device-number inputs are treated as unconstrained levels that change between edges. The bench changes them only on falling edges and covers even and odd device numbers in both modes.

// File: rtl/intx_router_pkg.sv
package intx_router_pkg;

    localparam int PINS_PER_DEV = 4;
    localparam int NUM_LINES    = 4;
    localparam int FOLD_LINES   = 2;

    localparam logic [1:0] SIZE_BYTE = 2'd0;

    typedef enum logic [2:0] {
        ACK_IDLE,
        ACK_STROBE,
        ACK_READ_DONE,
        ACK_WRITE_DONE,
        ACK_REJECT
    } ack_state_e;

endpackage

// File: rtl/intx_swizzle.sv
module intx_swizzle
    import intx_router_pkg::*;
#(
    parameter int NUM_DEV  = 4,
    parameter int DEVNUM_W = 5
) (
    input  logic [NUM_DEV*PINS_PER_DEV-1:0] dev_pins,
    input  logic [NUM_DEV*DEVNUM_W-1:0]     dev_num,
    output logic [NUM_LINES-1:0]            line_lvl
);

    logic [FOLD_LINES-1:0] contrib [NUM_DEV];
    logic [NUM_DEV-1:0]    unused_num_hi;

    for (genvar d = 0; d < NUM_DEV; d++) begin : g_dev
        logic [PINS_PER_DEV-1:0] pins;
        logic                    odd;

        assign pins = dev_pins[d*PINS_PER_DEV +: PINS_PER_DEV];
        assign odd  = dev_num[d*DEVNUM_W];
        assign unused_num_hi[d] = ^dev_num[d*DEVNUM_W +: DEVNUM_W];

        // even pins (A, C) land on the line matching the device parity
        assign contrib[d][0] = odd ? (pins[1] | pins[3]) : (pins[0] | pins[2]);
        assign contrib[d][1] = odd ? (pins[0] | pins[2]) : (pins[1] | pins[3]);
    end

    always_comb begin
        line_lvl = '0;
        for (int d = 0; d < NUM_DEV; d++) begin
            line_lvl[FOLD_LINES-1:0] = line_lvl[FOLD_LINES-1:0] | contrib[d];
        end
    end

endmodule

// File: rtl/intx_merge.sv
module intx_merge
    import intx_router_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 sep_mode,
    input  logic [NUM_LINES-1:0] line_lvl,
    output logic [NUM_LINES-1:0] irq_line,
    output logic                 irq_all
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_line <= '0;
            irq_all  <= 1'b0;
        end else if (sep_mode) begin
            irq_line <= line_lvl;
            irq_all  <= 1'b0;
        end else begin
            irq_line <= '0;
            irq_all  <= |line_lvl;
        end
    end

endmodule

// File: rtl/intx_ack_port.sv
module intx_ack_port
    import intx_router_pkg::*;
#(
    parameter logic [31:0] ACK_ADDR = 32'hBFFF_FFF0
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bus_req,
    input  logic        bus_we,
    input  logic [31:0] bus_addr,
    input  logic [1:0]  bus_size,
    input  logic [7:0]  bus_wdata,
    output logic [7:0]  bus_rdata,
    output logic        bus_rsp_valid,
    output logic        bus_rsp_err,
    output logic        ctl_ack_stb,
    input  logic [7:0]  ctl_vector
);

    ack_state_e state_q, state_d;
    logic       hit;
    logic [7:0] rdata_q;
    logic       unused_wdata;

    assign hit          = bus_req && (bus_addr == ACK_ADDR);
    assign unused_wdata = ^bus_wdata;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ACK_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ACK_IDLE: begin
                if (hit) begin
                    if (bus_size != SIZE_BYTE) state_d = ACK_REJECT;
                    else if (bus_we)           state_d = ACK_WRITE_DONE;
                    else                       state_d = ACK_STROBE;
                end
            end
            ACK_STROBE:     state_d = ACK_READ_DONE;
            ACK_READ_DONE:  state_d = ACK_IDLE;
            ACK_WRITE_DONE: state_d = ACK_IDLE;
            ACK_REJECT:     state_d = ACK_IDLE;
            default:        state_d = ACK_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n)                  rdata_q <= '0;
        else if (state_q == ACK_STROBE) rdata_q <= ctl_vector;
    end

    always_comb begin
        ctl_ack_stb   = 1'b0;
        bus_rsp_valid = 1'b0;
        bus_rsp_err   = 1'b0;
        unique case (state_q)
            ACK_IDLE:       ;
            ACK_STROBE:     ctl_ack_stb = 1'b1;
            ACK_READ_DONE:  bus_rsp_valid = 1'b1;
            ACK_WRITE_DONE: bus_rsp_valid = 1'b1;
            ACK_REJECT: begin
                bus_rsp_valid = 1'b1;
                bus_rsp_err   = 1'b1;
            end
            default:        ;
        endcase
    end

    assign bus_rdata = rdata_q;

endmodule

// File: rtl/intx_router.sv
module intx_router
    import intx_router_pkg::*;
#(
    parameter int          NUM_DEV  = 4,
    parameter int          DEVNUM_W = 5,
    parameter logic [31:0] ACK_ADDR = 32'hBFFF_FFF0
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            sep_mode,
    input  logic [NUM_DEV*PINS_PER_DEV-1:0] dev_pins,
    input  logic [NUM_DEV*DEVNUM_W-1:0]     dev_num,
    output logic [NUM_LINES-1:0]            irq_line,
    output logic                            irq_all,
    input  logic                            bus_req,
    input  logic                            bus_we,
    input  logic [31:0]                     bus_addr,
    input  logic [1:0]                      bus_size,
    input  logic [7:0]                      bus_wdata,
    output logic [7:0]                      bus_rdata,
    output logic                            bus_rsp_valid,
    output logic                            bus_rsp_err,
    output logic                            ctl_ack_stb,
    input  logic [7:0]                      ctl_vector
);

    logic [NUM_LINES-1:0] line_lvl;

    intx_swizzle #(
        .NUM_DEV (NUM_DEV),
        .DEVNUM_W(DEVNUM_W)
    ) u_swizzle (
        .dev_pins(dev_pins),
        .dev_num (dev_num),
        .line_lvl(line_lvl)
    );

    intx_merge u_merge (
        .clk     (clk),
        .rst_n   (rst_n),
        .sep_mode(sep_mode),
        .line_lvl(line_lvl),
        .irq_line(irq_line),
        .irq_all (irq_all)
    );

    intx_ack_port #(
        .ACK_ADDR(ACK_ADDR)
    ) u_ack (
        .clk          (clk),
        .rst_n        (rst_n),
        .bus_req      (bus_req),
        .bus_we       (bus_we),
        .bus_addr     (bus_addr),
        .bus_size     (bus_size),
        .bus_wdata    (bus_wdata),
        .bus_rdata    (bus_rdata),
        .bus_rsp_valid(bus_rsp_valid),
        .bus_rsp_err  (bus_rsp_err),
        .ctl_ack_stb  (ctl_ack_stb),
        .ctl_vector   (ctl_vector)
    );

endmodule

// File: rtl/intx_router_chk.sv
module intx_router_chk #(
    parameter int          NUM_DEV  = 4,
    parameter logic [31:0] ACK_ADDR = 32'hBFFF_FFF0
) (
    input logic              clk,
    input logic              rst_n,
    input logic              sep_mode,
    input logic [NUM_DEV*4-1:0] dev_pins,
    input logic [3:0]        irq_line,
    input logic              irq_all,
    input logic              bus_req,
    input logic              bus_we,
    input logic [31:0]       bus_addr,
    input logic [1:0]        bus_size,
    input logic [7:0]        bus_rdata,
    input logic              bus_rsp_valid,
    input logic              bus_rsp_err,
    input logic              ctl_ack_stb,
    input logic [7:0]        ctl_vector
);

    logic hit;
    assign hit = bus_req && (bus_addr == ACK_ADDR);

    // R3
    upper_lines_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sep_mode |=> (irq_line[3:2] == 2'b00) && !irq_all);

    // R4
    comb_mode_lines_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !sep_mode |=> (irq_line == 4'b0000));

    // R2
    quiet_pins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dev_pins == '0) |=> (irq_line == 4'b0000) && !irq_all);

    // R6
    strobe_after_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && !bus_we && bus_size == 2'd0) |=> ctl_ack_stb && !bus_rsp_valid);

    // R6
    strobe_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_ack_stb |=> !ctl_ack_stb);

    // R7
    read_vector_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_ack_stb |=> bus_rsp_valid && !bus_rsp_err && (bus_rdata == $past(ctl_vector)));

    // R8
    write_dropped_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && bus_we && bus_size == 2'd0) |=> bus_rsp_valid && !bus_rsp_err
                                               && !ctl_ack_stb && $stable(bus_rdata));

    // R9
    wide_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && bus_size != 2'd0) |=> bus_rsp_valid && bus_rsp_err && !ctl_ack_stb);

    // R10
    addr_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !hit) |=> !bus_rsp_valid && !ctl_ack_stb);

endmodule

bind intx_router intx_router_chk #(
    .NUM_DEV (NUM_DEV),
    .ACK_ADDR(ACK_ADDR)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .sep_mode     (sep_mode),
    .dev_pins     (dev_pins),
    .irq_line     (irq_line),
    .irq_all      (irq_all),
    .bus_req      (bus_req),
    .bus_we       (bus_we),
    .bus_addr     (bus_addr),
    .bus_size     (bus_size),
    .bus_rdata    (bus_rdata),
    .bus_rsp_valid(bus_rsp_valid),
    .bus_rsp_err  (bus_rsp_err),
    .ctl_ack_stb  (ctl_ack_stb),
    .ctl_vector   (ctl_vector)
);

// File: tb/test_intx_router.sv
module test_intx_router;

    localparam int CLK_PERIOD = 10;
    localparam int NUM_DEV    = 4;
    localparam int DEVNUM_W   = 5;
    localparam logic [31:0] ACK_ADDR = 32'hBFFF_FFF0;

    logic clk = 1'b0;
    logic rst_n;
    logic sep_mode;
    logic [NUM_DEV*4-1:0]        dev_pins;
    logic [NUM_DEV*DEVNUM_W-1:0] dev_num;
    logic [3:0]  irq_line;
    logic        irq_all;
    logic        bus_req, bus_we;
    logic [31:0] bus_addr;
    logic [1:0]  bus_size;
    logic [7:0]  bus_wdata, bus_rdata, ctl_vector;
    logic        bus_rsp_valid, bus_rsp_err, ctl_ack_stb;

    int total = 0;
    int bad   = 0;
    int cycles = 0;
    bit started = 0;
    logic [3:0] exp_line;
    logic       exp_all;
    logic [7:0] last_rdata;

    always #(CLK_PERIOD/2) clk = ~clk;

    intx_router #(
        .NUM_DEV (NUM_DEV),
        .DEVNUM_W(DEVNUM_W),
        .ACK_ADDR(ACK_ADDR)
    ) i_intx_router (
        .clk(clk), .rst_n(rst_n), .sep_mode(sep_mode),
        .dev_pins(dev_pins), .dev_num(dev_num),
        .irq_line(irq_line), .irq_all(irq_all),
        .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_size(bus_size), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .bus_rsp_valid(bus_rsp_valid), .bus_rsp_err(bus_rsp_err),
        .ctl_ack_stb(ctl_ack_stb), .ctl_vector(ctl_vector)
    );

    task automatic check(input bit ok, input string tag, input int act, input int expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, expv);
        end
    endtask

    // behavioural model of the interrupt outputs, one edge of latency
    always @(posedge clk) begin
        logic [1:0] lines;
        lines = 2'b00;
        for (int d = 0; d < NUM_DEV; d++) begin
            int dn;
            dn = int'(dev_num[d*DEVNUM_W +: DEVNUM_W]);
            for (int p = 0; p < 4; p++)
                if (dev_pins[d*4+p]) lines[(p + dn) % 2] = 1'b1;
        end
        if (!rst_n) begin
            exp_line <= 4'b0;
            exp_all  <= 1'b0;
        end else if (sep_mode) begin
            exp_line <= {2'b00, lines};
            exp_all  <= 1'b0;
        end else begin
            exp_line <= 4'b0;
            exp_all  <= |lines;
        end
        started <= 1'b1;
    end

    // compared on every clock: R1 R2 R3 R4 R5
    always @(negedge clk) begin
        if (started) begin
            check(irq_line == exp_line, "R1 R2 R3 R4 R5 irq_line", int'(irq_line), int'(exp_line));
            check(irq_all == exp_all, "R2 R3 R4 R5 irq_all", int'(irq_all), int'(exp_all));
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=%0d expected=done", cycles);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic set_dev(input int d, input logic [3:0] pins, input int dn);
        dev_pins[d*4 +: 4] = pins;
        dev_num[d*DEVNUM_W +: DEVNUM_W] = DEVNUM_W'(dn);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic issue(input logic we, input logic [31:0] a, input logic [1:0] sz, input logic [7:0] wd);
        bus_req = 1'b1; bus_we = we; bus_addr = a; bus_size = sz; bus_wdata = wd;
        @(negedge clk);
        bus_req = 1'b0;
    endtask

    task automatic ack_read(input logic [7:0] vec);
        ctl_vector = ~vec;
        issue(1'b0, ACK_ADDR, 2'd0, 8'h00);
        check(ctl_ack_stb == 1'b1, "R6 strobe raised", int'(ctl_ack_stb), 1);
        check(bus_rsp_valid == 1'b0, "R6 no early response", int'(bus_rsp_valid), 0);
        ctl_vector = vec;
        @(negedge clk);
        ctl_vector = ~vec;
        check(ctl_ack_stb == 1'b0, "R6 strobe one cycle", int'(ctl_ack_stb), 0);
        check(bus_rsp_valid && !bus_rsp_err, "R7 response ok", int'({bus_rsp_valid, bus_rsp_err}), 2);
        check(bus_rdata == vec, "R7 vector returned", int'(bus_rdata), int'(vec));
        last_rdata = vec;
        @(negedge clk);
        check(bus_rsp_valid == 1'b0, "R7 response one cycle", int'(bus_rsp_valid), 0);
    endtask

    task automatic ack_write(input logic [7:0] wd);
        issue(1'b1, ACK_ADDR, 2'd0, wd);
        check(bus_rsp_valid && !bus_rsp_err, "R8 write response", int'({bus_rsp_valid, bus_rsp_err}), 2);
        check(ctl_ack_stb == 1'b0, "R8 no strobe on write", int'(ctl_ack_stb), 0);
        check(bus_rdata == last_rdata, "R8 read data untouched", int'(bus_rdata), int'(last_rdata));
        @(negedge clk);
    endtask

    task automatic ack_wide(input logic we, input logic [1:0] sz);
        issue(we, ACK_ADDR, sz, 8'h5A);
        check(bus_rsp_valid && bus_rsp_err, "R9 wide access refused", int'({bus_rsp_valid, bus_rsp_err}), 3);
        check(ctl_ack_stb == 1'b0, "R9 no strobe", int'(ctl_ack_stb), 0);
        @(negedge clk);
    endtask

    task automatic ack_miss(input logic we, input logic [31:0] a);
        issue(we, a, 2'd0, 8'hA5);
        check(!bus_rsp_valid && !ctl_ack_stb, "R10 miss ignored", int'({bus_rsp_valid, ctl_ack_stb}), 0);
        @(negedge clk);
        check(!bus_rsp_valid && !ctl_ack_stb, "R10 miss still quiet", int'({bus_rsp_valid, ctl_ack_stb}), 0);
    endtask

    initial begin
        rst_n = 1'b0; sep_mode = 1'b1; dev_pins = '0; dev_num = '0;
        bus_req = 1'b0; bus_we = 1'b0; bus_addr = '0; bus_size = '0;
        bus_wdata = '0; ctl_vector = '0; last_rdata = 8'h00;
        set_dev(0, 4'hF, 1);
        sep_mode = 1'b0;
        idle(3);
        // R5 reset state despite active pins
        check(irq_line == 4'b0 && !irq_all, "R5 reset outputs", int'({irq_all, irq_line}), 0);
        check(!bus_rsp_valid && !ctl_ack_stb && bus_rdata == 8'h00, "R5 reset bus side",
              int'({bus_rsp_valid, ctl_ack_stb, bus_rdata}), 0);
        dev_pins = '0; dev_num = '0;
        sep_mode = 1'b1;
        rst_n = 1'b1;
        idle(2);

        // R1 separate mode: each pin of even and odd devices
        for (int p = 0; p < 4; p++) begin
            set_dev(0, 4'(1 << p), 0); idle(2);
            set_dev(0, 4'h0, 0);
            set_dev(1, 4'(1 << p), 7); idle(2);
            set_dev(1, 4'h0, 7);
            set_dev(2, 4'(1 << p), 30); idle(2);
            set_dev(2, 4'h0, 30); idle(1);
        end
        // R2 several sources on one line, then release one at a time
        set_dev(0, 4'b0001, 2); set_dev(3, 4'b0010, 5); idle(2);
        set_dev(0, 4'b0000, 2); idle(2);
        set_dev(3, 4'b0000, 5); idle(2);
        // both lines at once
        set_dev(1, 4'b0011, 4); idle(2);
        set_dev(2, 4'b1100, 9); idle(2);

        // R4 combined mode with the same inputs, then quiet
        sep_mode = 1'b0; idle(2);
        dev_pins = '0; idle(2);
        set_dev(3, 4'b1000, 17); idle(2);
        // R3 R4 mode toggling while pins held
        sep_mode = 1'b1; idle(1);
        sep_mode = 1'b0; idle(1);
        sep_mode = 1'b1; idle(2);
        dev_pins = '0; idle(2);

        // acknowledge port
        ack_read(8'h2C);
        ack_write(8'hFF);
        ack_read(8'h00);
        ack_read(8'hE7);
        ack_write(8'h11);
        ack_wide(1'b0, 2'd1);
        ack_wide(1'b0, 2'd2);
        ack_wide(1'b1, 2'd2);
        check(bus_rdata == last_rdata, "R9 read data untouched", int'(bus_rdata), int'(last_rdata));
        ack_miss(1'b0, ACK_ADDR + 32'd1);
        ack_miss(1'b1, ACK_ADDR - 32'd16);
        ack_miss(1'b0, 32'h0000_0000);
        // interrupts keep routing during bus traffic
        set_dev(2, 4'b0100, 3);
        ack_read(8'h81);
        idle(2);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule